// File: doc/BRIEF.md
# Dual-Half Timer/Counter

This block is a 16-bit timer/counter made of two 8-bit halves, a low half and a high half. It advances on every clock, or on each falling edge of an external count pin when external counting is selected. A 2-bit mode input picks how the halves work together: a 13-bit count whose low half acts as a divide-by-32 prescaler, a full 16-bit count, an 8-bit count that reloads from the high half on overflow, and a split mode in which the two halves run as separate 8-bit timers.

A run input starts and stops the main count. Either half can be written on any cycle, and a write wins over counting in that cycle. The overflow flag is set when the count wraps and stays set until an interrupt acknowledge or a software clear. In split mode the high half counts clock ticks under its own run input and sets a second overflow flag with its own clear. Split mode exists only when the `SPLIT_EN` parameter is set; an instance built without it freezes its count in mode 3.

Top module: `dual_half_timer`

## Requirements
- R1: After reset both halves read 0 and both overflow flags are 0.
- R2: With run_en at 0, no write and mode_sel other than 3, both halves keep their values.
- R3: In mode_sel 1 the halves form one 16-bit count {count_hi, count_lo}; the step from FFFFh to 0000h sets ovf_flag.
- R4: In mode_sel 0 bits 4:0 of count_lo count as a prescaler while bits 7:5 hold. A carry out of bit 4 increments count_hi. The wrap of the 13-bit value from 1FFFh to 0000h sets ovf_flag.
- R5: In mode_sel 2 count_lo counts. On a step from FFh it loads count_hi in that same cycle, count_hi is unchanged, and ovf_flag is set.
- R6: With count_ext at 1, only falling edges on count_pin are counted, at most one per clock. A pin driven low before clock edge k is counted at edge k+2. Rising edges and a pin held low add nothing more.
- R7: ovf_ack or ovf_sw_clr at 1 clears ovf_flag at the next clock edge.
- R8: A write to a half (wr_lo_en or wr_hi_en) loads wr_data at the next edge and cancels that cycle's increment. In modes 0 to 2 a write to either half cancels the whole step.
- R9: When an overflow and a clear request fall in the same cycle, ovf_flag ends up set.
- R10: In mode_sel 3 (SPLIT_EN=1) count_lo is an 8-bit count under run_en and sets ovf_flag on FFh to 00h. count_hi increments on every clock while hi_run_en is 1, whatever the count source. Its wrap sets hi_ovf_flag, which only hi_ovf_ack clears.
- R11: With SPLIT_EN=0, mode_sel 3 stops both halves, though writes still load them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | 0 prescaled 13-bit, 1 full 16-bit, 2 auto-reload 8-bit, 3 split |
| run_en | input | 1 | Run control for the main count (low half in split mode) |
| count_ext | input | 1 | 1 counts count_pin falling edges, 0 counts clocks |
| count_pin | input | 1 | External event input, asynchronous |
| hi_run_en | input | 1 | Run control for the high half in split mode |
| wr_lo_en | input | 1 | Load count_lo from wr_data |
| wr_hi_en | input | 1 | Load count_hi from wr_data |
| wr_data | input | HALF_W | Write data |
| ovf_sw_clr | input | 1 | Software clear of ovf_flag |
| ovf_ack | input | 1 | Interrupt acknowledge, clears ovf_flag |
| hi_ovf_ack | input | 1 | Clears hi_ovf_flag |
| count_lo | output | HALF_W | Low half value |
| count_hi | output | HALF_W | High half value |
| ovf_flag | output | 1 | Main overflow flag |
| hi_ovf_flag | output | 1 | High-half overflow flag in split mode |

## Verification
A write, a count step, a flag set and a flag clear each show one clock edge after the cycle that causes them. An external pin fall shows two edges later because of the synchronizer and history stage. The bench drives inputs on the falling clock edge and reads results on a later falling edge. It waits exactly as many rising edges as the rule requires and no more, so a result that comes early or late does not match the expected value. For the pin tests the bench allows extra settling cycles only after the pin has gone quiet, and checks the total number of counted edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      MODE_PRESCALED = 2'd0,
      MODE_FULL      = 2'd1,
      MODE_RELOAD    = 2'd2,
      MODE_SPLIT     = 2'd3
   } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);
   // pipe[STAGES-1] is the synchronized sample, pipe[STAGES] the previous one
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], pin_i};
   end

   assign fall_o = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_split_hi.sv
module tmr_split_hi #(
   parameter int W = 8
) (
   input  logic         in_split,
   input  logic         hi_run,
   input  logic         wr_hi,
   input  logic [W-1:0] hi_q,
   output logic         hi_inc,
   output logic         hi_evt
);
   assign hi_inc = in_split & hi_run & ~wr_hi;
   assign hi_evt = hi_inc & (&hi_q);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int W        = 8,
   parameter int PW       = 5,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode,
   input  logic         step,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wr_data,
   input  logic         hi_inc,
   output logic [W-1:0] lo_q,
   output logic [W-1:0] hi_q,
   output logic         ovf_evt
);
   localparam int CW = 2 * W;

   logic [W-1:0]  lo_d, hi_d;
   logic [CW-1:0] cat_inc;
   logic [PW-1:0] pre_inc;
   logic          pre_full, lo_full, hi_full, any_wr;

   assign cat_inc  = {hi_q, lo_q} + CW'(1);
   assign pre_inc  = lo_q[PW-1:0] + PW'(1);
   assign pre_full = &lo_q[PW-1:0];
   assign lo_full  = &lo_q;
   assign hi_full  = &hi_q;
   assign any_wr   = wr_lo | wr_hi;

   always_comb begin
      lo_d    = lo_q;
      hi_d    = hi_q;
      ovf_evt = 1'b0;
      case (mode)
         MODE_PRESCALED: begin
            if (step && !any_wr) begin
               lo_d[PW-1:0] = pre_inc;
               if (pre_full) begin
                  hi_d    = hi_q + W'(1);
                  ovf_evt = hi_full;
               end
            end
         end
         MODE_FULL: begin
            if (step && !any_wr) begin
               {hi_d, lo_d} = cat_inc;
               ovf_evt      = lo_full & hi_full;
            end
         end
         MODE_RELOAD: begin
            if (step && !any_wr) begin
               if (lo_full) begin
                  lo_d    = hi_q;
                  ovf_evt = 1'b1;
               end else begin
                  lo_d = lo_q + W'(1);
               end
            end
         end
         MODE_SPLIT: begin
            if (SPLIT_EN) begin
               if (step && !wr_lo) begin
                  lo_d    = lo_q + W'(1);
                  ovf_evt = lo_full;
               end
               if (hi_inc) hi_d = hi_q + W'(1);
            end
         end
         default: ;
      endcase
      if (wr_lo) lo_d = wr_data;
      if (wr_hi) hi_d = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
   import tmr_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int PRESCALE_W  = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit SPLIT_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              run_en,
   input  logic              count_ext,
   input  logic              count_pin,
   input  logic              hi_run_en,
   input  logic              wr_lo_en,
   input  logic              wr_hi_en,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              ovf_sw_clr,
   input  logic              ovf_ack,
   input  logic              hi_ovf_ack,
   output logic [HALF_W-1:0] count_lo,
   output logic [HALF_W-1:0] count_hi,
   output logic              ovf_flag,
   output logic              hi_ovf_flag
);
   if (HALF_W < 4) begin : g_bad_width
      $error("HALF_W must be at least 4");
   end
   if (PRESCALE_W < 1 || PRESCALE_W >= HALF_W) begin : g_bad_prescale
      $error("PRESCALE_W must lie between 1 and HALF_W-1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   tmr_mode_e mode;
   logic      pin_fall, tick, step;
   logic      hi_inc, hi_evt, main_evt;

   assign mode = tmr_mode_e'(mode_sel);

   tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (count_pin),
      .fall_o (pin_fall)
   );

   assign tick = count_ext ? pin_fall : 1'b1;
   assign step = run_en & tick;

   if (SPLIT_EN) begin : g_split
      tmr_split_hi #(.W(HALF_W)) u_split_hi (
         .in_split (mode == MODE_SPLIT),
         .hi_run   (hi_run_en),
         .wr_hi    (wr_hi_en),
         .hi_q     (count_hi),
         .hi_inc   (hi_inc),
         .hi_evt   (hi_evt)
      );
   end else begin : g_no_split
      assign hi_inc = 1'b0;
      assign hi_evt = 1'b0;
   end

   tmr_count_core #(
      .W        (HALF_W),
      .PW       (PRESCALE_W),
      .SPLIT_EN (SPLIT_EN)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .step    (step),
      .wr_lo   (wr_lo_en),
      .wr_hi   (wr_hi_en),
      .wr_data (wr_data),
      .hi_inc  (hi_inc),
      .lo_q    (count_lo),
      .hi_q    (count_hi),
      .ovf_evt (main_evt)
   );

   tmr_flag u_main_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (main_evt),
      .clr_i  (ovf_ack | ovf_sw_clr),
      .flag_o (ovf_flag)
   );

   tmr_flag u_hi_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hi_evt),
      .clr_i  (hi_ovf_ack),
      .flag_o (hi_ovf_flag)
   );
endmodule

// File: rtl/dual_half_timer_chk.sv
module dual_half_timer_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   mode_sel,
   input logic         run_en,
   input logic         count_ext,
   input logic         wr_lo_en,
   input logic         wr_hi_en,
   input logic [W-1:0] wr_data,
   input logic         ovf_sw_clr,
   input logic         ovf_ack,
   input logic [W-1:0] count_lo,
   input logic [W-1:0] count_hi,
   input logic         ovf_flag,
   input logic         hi_ovf_flag
);
   assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_lo_en && !wr_hi_en && mode_sel != 2'd3)
      |=> ($stable(count_lo) && $stable(count_hi)));

   assert_full_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovf_flag) && $past(mode_sel) == 2'd1)
      |-> ((&$past(count_lo)) && (&$past(count_hi))));

   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd2 && run_en && !count_ext && (&count_lo) && !wr_lo_en && !wr_hi_en)
      |=> (count_lo == $past(count_hi) && ovf_flag));

   assert_one_per_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'd1 && count_ext && !wr_lo_en && !wr_hi_en)
      |=> (count_lo == $past(count_lo) || count_lo == $past(count_lo) + W'(1)));

   assert_clear_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_flag) |-> ($past(ovf_ack) || $past(ovf_sw_clr)));

   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_en |=> (count_lo == $past(wr_data)));

   assert_hi_flag_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_ovf_flag) |-> ($past(mode_sel) == 2'd3));
endmodule

bind dual_half_timer dual_half_timer_chk #(.W(HALF_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sel    (mode_sel),
   .run_en      (run_en),
   .count_ext   (count_ext),
   .wr_lo_en    (wr_lo_en),
   .wr_hi_en    (wr_hi_en),
   .wr_data     (wr_data),
   .ovf_sw_clr  (ovf_sw_clr),
   .ovf_ack     (ovf_ack),
   .count_lo    (count_lo),
   .count_hi    (count_hi),
   .ovf_flag    (ovf_flag),
   .hi_ovf_flag (hi_ovf_flag)
);

// File: tb/dual_half_timer_tb.sv
module dual_half_timer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_sel = 2'd1;
   logic         run_en = 1'b0, count_ext = 1'b0, count_pin = 1'b1, hi_run_en = 1'b0;
   logic         wr_lo_en = 1'b0, wr_hi_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         ovf_sw_clr = 1'b0, ovf_ack = 1'b0, hi_ovf_ack = 1'b0;
   logic [W-1:0] count_lo, count_hi, ns_lo, ns_hi;
   logic         ovf_flag, hi_ovf_flag, ns_ovf, ns_hi_ovf;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_half_timer #(.SPLIT_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .run_en(run_en),
      .count_ext(count_ext), .count_pin(count_pin), .hi_run_en(hi_run_en),
      .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
      .ovf_sw_clr(ovf_sw_clr), .ovf_ack(ovf_ack), .hi_ovf_ack(hi_ovf_ack),
      .count_lo(count_lo), .count_hi(count_hi),
      .ovf_flag(ovf_flag), .hi_ovf_flag(hi_ovf_flag)
   );

   dual_half_timer #(.SPLIT_EN(1'b0)) u_dut_nosplit (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .run_en(run_en),
      .count_ext(count_ext), .count_pin(count_pin), .hi_run_en(hi_run_en),
      .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
      .ovf_sw_clr(ovf_sw_clr), .ovf_ack(ovf_ack), .hi_ovf_ack(hi_ovf_ack),
      .count_lo(ns_lo), .count_hi(ns_hi),
      .ovf_flag(ns_ovf), .hi_ovf_flag(ns_hi_ovf)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Loads both halves with run_en low; returns on a falling edge
   task automatic load(input logic [W-1:0] lo, input logic [W-1:0] hi);
      @(negedge clk); wr_lo_en = 1'b1; wr_data = lo;
      @(negedge clk); wr_lo_en = 1'b0; wr_hi_en = 1'b1; wr_data = hi;
      @(negedge clk); wr_hi_en = 1'b0;
   endtask

   task automatic clear_flag();
      ovf_sw_clr = 1'b1; cycles(1); ovf_sw_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "lo after reset", count_lo, 0);
      check("R1", "hi after reset", count_hi, 0);
      check("R1", "ovf after reset", ovf_flag, 0);
      check("R1", "hi_ovf after reset", hi_ovf_flag, 0);
   endtask

   task automatic t_full_wrap();
      mode_sel = 2'd1; load(8'hFD, 8'hFF);
      run_en = 1'b1; cycles(2); run_en = 1'b0;
      check("R3", "ovf before wrap", ovf_flag, 0);
      check("R3", "lo before wrap", count_lo, 8'hFF);
      run_en = 1'b1; cycles(1); run_en = 1'b0;
      check("R3", "lo at wrap", count_lo, 0);
      check("R3", "hi at wrap", count_hi, 0);
      check("R3", "ovf at wrap", ovf_flag, 1);
      ovf_ack = 1'b1; cycles(1); ovf_ack = 1'b0;
      check("R7", "ovf after ack", ovf_flag, 0);
   endtask

   task automatic t_hold();
      mode_sel = 2'd1; load(8'h34, 8'h12);
      cycles(5);
      check("R2", "lo held", count_lo, 8'h34);
      check("R2", "hi held", count_hi, 8'h12);
   endtask

   task automatic t_prescaled();
      mode_sel = 2'd0; load(8'hFF, 8'h12);
      run_en = 1'b1; cycles(1); run_en = 1'b0;
      check("R4", "lo prescaler wrap keeps top bits", count_lo, 8'hE0);
      check("R4", "hi carry", count_hi, 8'h13);
      check("R4", "no ovf mid count", ovf_flag, 0);
      load(8'h1E, 8'hFF);
      run_en = 1'b1; cycles(2); run_en = 1'b0;
      check("R4", "lo after 13-bit wrap", count_lo, 0);
      check("R4", "hi after 13-bit wrap", count_hi, 0);
      check("R4", "ovf on 13-bit wrap", ovf_flag, 1);
      clear_flag();
      check("R7", "ovf after sw clear", ovf_flag, 0);
   endtask

   task automatic t_reload();
      mode_sel = 2'd2; load(8'hFE, 8'h80);
      run_en = 1'b1; cycles(2);
      check("R5", "lo reloaded", count_lo, 8'h80);
      check("R5", "ovf on reload", ovf_flag, 1);
      cycles(1); run_en = 1'b0;
      check("R5", "lo counts after reload", count_lo, 8'h81);
      check("R5", "hi unchanged", count_hi, 8'h80);
      clear_flag();
   endtask

   task automatic t_external();
      mode_sel = 2'd1; count_ext = 1'b1; count_pin = 1'b1; load(8'h00, 8'h00);
      run_en = 1'b1;
      // edge latency: pin low before edge k counts at edge k+2
      count_pin = 1'b0; cycles(2);
      check("R6", "not yet counted", count_lo, 0);
      cycles(1);
      check("R6", "counted at third edge", count_lo, 1);
      count_pin = 1'b1; cycles(3);
      for (int i = 0; i < 3; i++) begin
         count_pin = 1'b0; cycles(3);
         count_pin = 1'b1; cycles(3);
      end
      cycles(4);
      check("R6", "pulse train", count_lo, 4);
      count_pin = 1'b0; cycles(10); count_pin = 1'b1; cycles(4);
      check("R6", "held low counts once", count_lo, 5);
      for (int i = 0; i < 8; i++) begin
         count_pin = (i % 2 == 0) ? 1'b0 : 1'b1; cycles(1);
      end
      count_pin = 1'b1; cycles(4);
      check("R6", "fast toggle", count_lo, 9);
      check("R6", "hi untouched", count_hi, 0);
      run_en = 1'b0; count_ext = 1'b0;
   endtask

   task automatic t_write_priority();
      mode_sel = 2'd1; load(8'h10, 8'h00);
      run_en = 1'b1; cycles(2);
      wr_lo_en = 1'b1; wr_data = 8'h40; cycles(1); wr_lo_en = 1'b0;
      check("R8", "write wins over step", count_lo, 8'h40);
      cycles(1);
      check("R8", "count resumes", count_lo, 8'h41);
      wr_hi_en = 1'b1; wr_data = 8'h77; cycles(1); wr_hi_en = 1'b0;
      check("R8", "hi write cancels step of lo", count_lo, 8'h41);
      check("R8", "hi written", count_hi, 8'h77);
      run_en = 1'b0;
   endtask

   task automatic t_set_beats_clear();
      mode_sel = 2'd1; load(8'hFF, 8'hFF);
      run_en = 1'b1; ovf_sw_clr = 1'b1; ovf_ack = 1'b1; cycles(1);
      run_en = 1'b0; ovf_sw_clr = 1'b0; ovf_ack = 1'b0;
      check("R9", "set beats clear", ovf_flag, 1);
      clear_flag();
   endtask

   task automatic t_split();
      mode_sel = 2'd3; hi_run_en = 1'b0; load(8'hFE, 8'hFE);
      run_en = 1'b1; hi_run_en = 1'b1; cycles(2); run_en = 1'b0;
      check("R10", "lo wrap", count_lo, 0);
      check("R10", "lo ovf", ovf_flag, 1);
      check("R10", "hi wrap", count_hi, 0);
      check("R10", "hi ovf", hi_ovf_flag, 1);
      check("R11", "no-split lo frozen", ns_lo, 8'hFE);
      check("R11", "no-split hi frozen", ns_hi, 8'hFE);
      hi_ovf_ack = 1'b1; cycles(1); hi_ovf_ack = 1'b0;
      check("R10", "hi ovf cleared by its ack", hi_ovf_flag, 0);
      check("R10", "main ovf kept", ovf_flag, 1);
      check("R10", "hi counts without run_en", count_hi, 1);
      hi_run_en = 1'b0; run_en = 1'b1; cycles(3); run_en = 1'b0;
      check("R10", "lo counts alone", count_lo, 3);
      check("R10", "hi holds", count_hi, 1);
      count_ext = 1'b1; count_pin = 1'b1; run_en = 1'b1; hi_run_en = 1'b1;
      cycles(4);
      run_en = 1'b0; hi_run_en = 1'b0; count_ext = 1'b0;
      check("R10", "lo waits for pin", count_lo, 3);
      check("R10", "hi counts clocks", count_hi, 5);
      check("R11", "no-split still frozen", ns_lo, 8'hFE);
      clear_flag();
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_full_wrap();
      t_hold();
      t_prescaled();
      t_reload();
      t_external();
      t_write_priority();
      t_set_beats_clear();
      t_split();
      cycles(2);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule